// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Doorbell Flags

This block is a synchronous memory with two fully independent ports, left and right, sharing one array of words. Each port has an active-low enable, a write strobe (low for write, high for read), an active-low output enable, an address, write data and registered read data. Any port can read or write any location, so the two sides can pass data blocks to each other through the shared array.

The two highest addresses double as doorbells. The top address (all ones) is the right side's mailbox: a left-port write there drops the right-side interrupt, and a right-port read of it raises the interrupt back to idle. The next address down (all ones except bit 0) is the left side's mailbox, with the roles swapped. The word written to a mailbox is also kept in the array, so the receiving side reads the message and acknowledges the doorbell in one access. Each port has an active-low busy input; while it is low, that port's accesses move no doorbell flag. The address width is a parameter: the 8192 x 18 configuration uses `ADDR_W = 13`; the default is smaller to keep elaboration light.

Top module: `dpm_mailbox`

## Requirements
- R1: While reset is low, and for the cycles until its synchronised release, both interrupt outputs are high and both read-data outputs are zero.
- R2: A port access with enable low and write strobe low stores the write data at the address; a later read of that address from either port returns it. A read in the same cycle as the other port's write to that address returns the previous word.
- R3: A read happens only with enable low, write strobe high and output enable low; its data appears on the port's read-data output one clock later. In any other cycle the read-data output holds its value.
- R4: A left-port write to the top address (all ones) drives the right interrupt low one clock later, and the word is stored in the array.
- R5: A right-port read of the top address drives the right interrupt high one clock later; the same access with output enable high leaves the flag low.
- R6: A right-port write to the address one below the top (all ones except bit 0) drives the left interrupt low one clock later.
- R7: A left-port read of the address one below the top drives the left interrupt high one clock later.
- R8: A port clears only its own flag and sets only the opposite one: a left read of the top address, a right read of the address below it, and a write by a port to its own mailbox address leave both flags unchanged.
- R9: While a port's busy input is low, its accesses change neither interrupt flag; array writes still take place.
- R10: When a set and a clear reach the same flag in the same cycle, the flag ends up asserted (low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| l_ce_n | input | 1 | Left enable, active low |
| l_we_n | input | 1 | Left write strobe, low writes, high reads |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_n | input | 1 | Left busy, low blocks left doorbell effects |
| l_rdata | output | DATA_W | Left registered read data |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right enable, active low |
| r_we_n | input | 1 | Right write strobe, low writes, high reads |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_n | input | 1 | Right busy, low blocks right doorbell effects |
| r_rdata | output | DATA_W | Right registered read data |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The bench aims at a doorbell being set and acknowledged in the same cycle, where a design that ordered clear over set would lose a message and leave the receiver idle. It reads each mailbox from the wrong side and writes each one from its own side, which would knock a flag over in a design that decoded only the address and not the port. It holds busy low during mailbox writes and reads, so a design that ignored busy would move a flag, and it reads with output enable high, which a loose decoder would treat as an acknowledge. Random traffic over a small address pool, with reads racing writes from the other port, exposes read data taken after rather than before the write.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  localparam int NUM_PORTS = 2;
  localparam int PORT_L    = 0;
  localparam int PORT_R    = 1;

  function automatic acc_kind_e classify(input logic ce_n, input logic we_n, input logic oe_n);
    if (ce_n)       return ACC_IDLE;
    else if (!we_n) return ACC_WRITE;
    else if (!oe_n) return ACC_READ;
    else            return ACC_IDLE;
  endfunction
endpackage

// File: rtl/dpm_port_ctrl.sv
module dpm_port_ctrl
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] SET_ADDR = '1,
  parameter logic [ADDR_W-1:0] CLR_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_n_i,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              set_o,
  output logic              clr_o
);
  acc_kind_e kind;

  always_comb begin
    kind    = classify(ce_n_i, we_n_i, oe_n_i);
    rd_en_o = (kind == ACC_READ);
    wr_en_o = (kind == ACC_WRITE);
    set_o   = wr_en_o && busy_n_i && (addr_i == SET_ADDR);
    clr_o   = rd_en_o && busy_n_i && (addr_i == CLR_ADDR);
  end

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n_i |-> !(set_o || clr_o));

  // R5
  no_clr_without_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !clr_o);
endmodule

// File: rtl/dpm_array.sv
module dpm_array
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i [NUM_PORTS],
  input  logic              wr_en_i [NUM_PORTS],
  input  logic [ADDR_W-1:0] addr_i  [NUM_PORTS],
  input  logic [DATA_W-1:0] wdata_i [NUM_PORTS],
  output logic [DATA_W-1:0] rdata_o [NUM_PORTS]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (wr_en_i[p]) mem[addr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_rd
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
      rdata_d = rdata_q;
      if (rd_en_i[gp]) rdata_d = mem[addr_i[gp]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rdata_q <= '0;
      else if (rd_en_i[gp]) rdata_q <= rdata_d;
    end

    assign rdata_o[gp] = rdata_q;

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i[gp] |=> $stable(rdata_o[gp]));
  end
endmodule

// File: rtl/dpm_flag.sv
module dpm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic int_n_o
);
  logic pend_d;
  logic pend_q;

  always_comb begin
    pend_d = pend_q;
    if (set_i)      pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pend_q <= 1'b0;
    else if (set_i || clr_i)  pend_q <= pend_d;
  end

  assign int_n_o = ~pend_q;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !int_n_o);

  // R7
  clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> int_n_o);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(int_n_o));
endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_n,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_int_n,
  input  logic              r_ce_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_n,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_int_n
);
  localparam logic [ADDR_W-1:0] MBX_RIGHT = '1;
  localparam logic [ADDR_W-1:0] MBX_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [1:0] rst_pipe;
  logic       rst_sys_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sys_n = rst_pipe[1];

  logic              ce_n   [NUM_PORTS];
  logic              we_n   [NUM_PORTS];
  logic              oe_n   [NUM_PORTS];
  logic              busy_n [NUM_PORTS];
  logic [ADDR_W-1:0] addr   [NUM_PORTS];
  logic [DATA_W-1:0] wdata  [NUM_PORTS];
  logic [DATA_W-1:0] rdata  [NUM_PORTS];
  logic              rd_en  [NUM_PORTS];
  logic              wr_en  [NUM_PORTS];
  logic              set    [NUM_PORTS];
  logic              clr    [NUM_PORTS];
  logic              int_n  [NUM_PORTS];

  always_comb begin
    ce_n[PORT_L]   = l_ce_n;   ce_n[PORT_R]   = r_ce_n;
    we_n[PORT_L]   = l_we_n;   we_n[PORT_R]   = r_we_n;
    oe_n[PORT_L]   = l_oe_n;   oe_n[PORT_R]   = r_oe_n;
    busy_n[PORT_L] = l_busy_n; busy_n[PORT_R] = r_busy_n;
    addr[PORT_L]   = l_addr;   addr[PORT_R]   = r_addr;
    wdata[PORT_L]  = l_wdata;  wdata[PORT_R]  = r_wdata;
  end

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN_MBX   = (gp == PORT_L) ? MBX_LEFT  : MBX_RIGHT;
    localparam logic [ADDR_W-1:0] OTHER_MBX = (gp == PORT_L) ? MBX_RIGHT : MBX_LEFT;

    dpm_port_ctrl #(
      .ADDR_W   (ADDR_W),
      .SET_ADDR (OTHER_MBX),
      .CLR_ADDR (OWN_MBX)
    ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_sys_n),
      .ce_n_i   (ce_n[gp]),
      .we_n_i   (we_n[gp]),
      .oe_n_i   (oe_n[gp]),
      .addr_i   (addr[gp]),
      .busy_n_i (busy_n[gp]),
      .rd_en_o  (rd_en[gp]),
      .wr_en_o  (wr_en[gp]),
      .set_o    (set[gp]),
      .clr_o    (clr[gp])
    );

    dpm_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_sys_n),
      .set_i   (set[NUM_PORTS-1-gp]),
      .clr_i   (clr[gp]),
      .int_n_o (int_n[gp])
    );
  end

  dpm_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_sys_n),
    .rd_en_i (rd_en),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign l_rdata = rdata[PORT_L];
  assign r_rdata = rdata[PORT_R];
  assign l_int_n = int_n[PORT_L];
  assign r_int_n = int_n[PORT_R];

  // R4
  left_rings_right_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (!l_ce_n && !l_we_n && l_busy_n && l_addr == MBX_RIGHT) |=> !r_int_n);

  // R6
  right_rings_left_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (!r_ce_n && !r_we_n && r_busy_n && r_addr == MBX_LEFT) |=> !l_int_n);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_sys_n |=> (!rst_sys_n || $past(!rst_sys_n)) |-> (l_int_n && r_int_n));
endmodule

// File: tb/dpm_mailbox_bench.sv
module dpm_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 18;
  localparam logic [AW-1:0] TOP  = '1;
  localparam logic [AW-1:0] TOP1 = {{(AW-1){1'b1}}, 1'b0};

  logic clk, rst_n;
  logic l_ce_n, l_we_n, l_oe_n, l_busy_n, r_ce_n, r_we_n, r_oe_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_int_n, r_int_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW-1:0] mdl [1 << AW];
  logic [DW-1:0] exp_rl, exp_rr;
  logic exp_il, exp_ir;

  dpm_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u_dpm_mailbox (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_busy_n(l_busy_n), .l_rdata(l_rdata), .l_int_n(l_int_n),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_busy_n(r_busy_n), .r_rdata(r_rdata), .r_int_n(r_int_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "l_int_n", DW'(l_int_n), DW'(exp_il));
    check(tag, "r_int_n", DW'(r_int_n), DW'(exp_ir));
    check(tag, "l_rdata", l_rdata, exp_rl);
    check(tag, "r_rdata", r_rdata, exp_rr);
  endtask

  task automatic drive_l(logic ce, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d, logic busy);
    l_ce_n = ce; l_we_n = we; l_oe_n = oe; l_addr = a; l_wdata = d; l_busy_n = busy;
  endtask

  task automatic drive_r(logic ce, logic we, logic oe, logic [AW-1:0] a, logic [DW-1:0] d, logic busy);
    r_ce_n = ce; r_we_n = we; r_oe_n = oe; r_addr = a; r_wdata = d; r_busy_n = busy;
  endtask

  task automatic idle_all();
    drive_l(1'b1, 1'b1, 1'b1, '0, '0, 1'b1);
    drive_r(1'b1, 1'b1, 1'b1, '0, '0, 1'b1);
  endtask

  // Bench model: one cycle of the requirements applied to the current inputs.
  task automatic step(string tag);
    logic rdl, rdr, wrl, wrr, sr, cr, sl, cl;
    rdl = !l_ce_n && l_we_n && !l_oe_n;
    rdr = !r_ce_n && r_we_n && !r_oe_n;
    wrl = !l_ce_n && !l_we_n;
    wrr = !r_ce_n && !r_we_n;
    if (rdl) exp_rl = mdl[l_addr];
    if (rdr) exp_rr = mdl[r_addr];
    sr = wrl && l_busy_n && l_addr == TOP;
    cr = rdr && r_busy_n && r_addr == TOP;
    sl = wrr && r_busy_n && r_addr == TOP1;
    cl = rdl && l_busy_n && l_addr == TOP1;
    if (sr) exp_ir = 1'b0; else if (cr) exp_ir = 1'b1;
    if (sl) exp_il = 1'b0; else if (cl) exp_il = 1'b1;
    if (wrl) mdl[l_addr] = l_wdata;
    if (wrr) mdl[r_addr] = r_wdata;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int k;
    k = int'($urandom_range(0, 7));
    if (k == 6) return TOP1;
    if (k == 7) return TOP;
    return AW'(k);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    idle_all();
    exp_rl = '0; exp_rr = '0; exp_il = 1'b1; exp_ir = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    repeat (3) @(negedge clk);
    check_all("R1");

    // Fill the address pool with busy held low: no flag may move (R9).
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      a = (i == 6) ? TOP1 : (i == 7) ? TOP : AW'(i);
      drive_l(1'b0, 1'b0, 1'b1, a, DW'(18'h100 + i), 1'b0);
      step("R9");
    end
    idle_all();

    // R2: left write, right read back
    drive_l(1'b0, 1'b0, 1'b1, AW'(3), 18'h2A5A5, 1'b1); step("R2");
    idle_all();
    drive_r(1'b0, 1'b1, 1'b0, AW'(3), '0, 1'b1); step("R2");
    // R2: same-cycle read of a word being written by the other port sees the old word
    drive_l(1'b0, 1'b0, 1'b1, AW'(4), 18'h3FFFF, 1'b1);
    drive_r(1'b0, 1'b1, 1'b0, AW'(4), '0, 1'b1); step("R2");
    idle_all();
    drive_l(1'b0, 1'b1, 1'b0, AW'(4), '0, 1'b1); step("R2");
    idle_all();
    // R3: output enable high: no read, data holds
    drive_r(1'b0, 1'b1, 1'b1, AW'(0), '0, 1'b1); step("R3");
    drive_r(1'b1, 1'b1, 1'b0, AW'(1), '0, 1'b1); step("R3");
    idle_all();

    // R4: left rings right, message stored
    drive_l(1'b0, 1'b0, 1'b1, TOP, 18'h1BEEF, 1'b1); step("R4");
    idle_all();
    // R5: read without output enable leaves flag low
    drive_r(1'b0, 1'b1, 1'b1, TOP, '0, 1'b1); step("R5");
    // R9: busy right blocks the acknowledge
    drive_r(1'b0, 1'b1, 1'b0, TOP, '0, 1'b0); step("R9");
    // R5: acknowledge, message read
    drive_r(1'b0, 1'b1, 1'b0, TOP, '0, 1'b1); step("R5");
    idle_all();

    // R6: right rings left
    drive_r(1'b0, 1'b0, 1'b1, TOP1, 18'h0C0DE, 1'b1); step("R6");
    idle_all();
    // R8: wrong-side accesses leave flags alone
    drive_r(1'b0, 1'b1, 1'b0, TOP1, '0, 1'b1); step("R8");
    idle_all();
    drive_l(1'b0, 1'b0, 1'b1, TOP1, 18'h01111, 1'b1); step("R8");
    idle_all();
    drive_l(1'b0, 1'b1, 1'b0, TOP, '0, 1'b1); step("R8");
    drive_r(1'b0, 1'b0, 1'b1, TOP, 18'h02222, 1'b1); step("R8");
    idle_all();
    // R9 then R7: left acknowledge, first blocked by busy
    drive_l(1'b0, 1'b1, 1'b0, TOP1, '0, 1'b0); step("R9");
    drive_l(1'b0, 1'b1, 1'b0, TOP1, '0, 1'b1); step("R7");
    idle_all();

    // R10: set and clear of the same flag together
    drive_l(1'b0, 1'b0, 1'b1, TOP, 18'h0AAAA, 1'b1);
    drive_r(1'b0, 1'b1, 1'b0, TOP, '0, 1'b1); step("R10");
    drive_r(1'b0, 1'b0, 1'b1, TOP1, 18'h05555, 1'b1);
    drive_l(1'b0, 1'b1, 1'b0, TOP1, '0, 1'b1); step("R10");
    idle_all();

    // Random traffic over the pool
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] al, ar;
      al = pick_addr(); ar = pick_addr();
      drive_l(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom_range(0, 3) == 0),
              al, DW'($urandom), 1'($urandom_range(0, 4) != 0));
      drive_r(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom_range(0, 3) == 0),
              ar, DW'($urandom), 1'($urandom_range(0, 4) != 0));
      if (!l_ce_n && !l_we_n && !r_ce_n && !r_we_n && al == ar) r_we_n = 1'b1;
      step("R2 R4 R5 R6 R7 R8 R9 R10");
    end
    idle_all();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule